// File: doc/BRIEF.md
# Indexed Address Window Bridge

This bridge gives a host a narrow register window into a 28-bit internal command and data space. The window has two 32-bit registers. The host first writes a target address into the control register. It then reads or writes the data register, and each data access becomes exactly one internal read or write at the held address. The held address stays in place until the next control write, so a run of data accesses all reach the same internal location.

The held address is split into three fields for downstream steering: a 2-bit map selector in the top bits, a bank number just below it, and a low field. When the map selector is all ones, the low field also names a bus cycle kind. Each forwarded access raises a one-hot map strobe alongside the internal request.

A read of the data register holds the host (no acknowledge) until the internal side returns its response. The internal request uses a valid/ready handshake, and a separate response-valid pulse returns the read data.

Top module: `idxwin_bridge`

## Requirements
- R1: After reset the held address is zero, `int_valid` and `host_ack` are low, `map_strobe` is zero, and a control read returns 0.
- R2: A host write to offset 0x00 stores `host_wdata[27:0]` as the held address, and bits 31:28 are dropped. A host read of offset 0x00 returns the held address zero-extended to 32 bits. Either access is acknowledged one cycle after the request.
- R3: `map_sel` equals held bits 27:26, `bank_sel` equals bits 25:24, and `low_field` equals bits 23:0.
- R4: `cyc_kind` is 0 (command), 1 (address) or 2 (data) when `map_sel` is 3 and `low_field` is 0, 1 or 2 respectively. It is 3 (no cycle) in every other case.
- R5: A host write to offset 0x10 issues exactly one internal write carrying the held address and the host data. The host is acknowledged in the cycle after the handshake completes.
- R6: A host read of offset 0x10 issues exactly one internal read at the held address. `host_ack` stays low until `int_rsp_valid`, and `host_rdata` equals `int_rsp_data` when `host_ack` rises. With a ready delay of d cycles and a response delay of r cycles, the acknowledge arrives d+r+3 cycles after the request.
- R7: While `int_valid` is high and `int_ready` is low, the request address, direction and write data hold steady.
- R8: Data accesses leave the held address unchanged, so consecutive data accesses target the same internal address.
- R9: At any offset other than 0x00 and 0x10, a write has no effect and a read returns 0. No internal access is issued, and the acknowledge still comes one cycle later.
- R10: A host request that arrives while a data access is in progress is dropped. It produces neither an acknowledge nor a change to the held address.
- R11: `map_strobe` is all zeros when no request is pending. It is one-hot, with bit `map_sel` set, for every cycle `int_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle host request pulse |
| host_we | input | 1 | Host request is a write |
| host_addr | input | 5 | Byte offset within the window |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| int_valid | output | 1 | Internal request pending |
| int_ready | input | 1 | Internal side accepts the request |
| int_write | output | 1 | Internal request is a write |
| int_addr | output | 28 | Internal request address |
| int_wdata | output | 32 | Internal write data |
| int_rsp_valid | input | 1 | Internal read response valid |
| int_rsp_data | input | 32 | Internal read response data |
| map_sel | output | 2 | Map field of the held address |
| bank_sel | output | 2 | Bank field of the held address |
| low_field | output | 24 | Low field of the held address |
| cyc_kind | output | 2 | Bus cycle kind for map 3 |
| map_strobe | output | 4 | One-hot map select during a request |

## Verification
If the held address is corrupted, the effect shows up at the ports as soon as the next control read or the next forwarded request. The decode outputs change in the same cycle the register does. A stuck or skipped sequencer state shows up as an acknowledge that comes too early, too late, or more than once, so the bench compares acknowledge latency against the exact count derived from the responder delays. A dropped or duplicated internal access shows up in the responder's access counts within one transfer.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DATA = 2'd2,
    CYC_NONE = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CTRL = 2'd1,
    HIT_DATA = 2'd2
  } hit_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fwd_state_e;
endpackage

// File: rtl/idxwin_host_decode.sv
module idxwin_host_decode
  import idxwin_pkg::*;
#(
  parameter int HOST_AW  = 5,
  parameter int CTRL_OFF = 0,
  parameter int DATA_OFF = 16
) (
  input  logic [HOST_AW-1:0] host_addr,
  output hit_e               hit
);
  localparam logic [HOST_AW-1:0] CTRL_A = HOST_AW'(CTRL_OFF);
  localparam logic [HOST_AW-1:0] DATA_A = HOST_AW'(DATA_OFF);

  always_comb begin
    if (host_addr == CTRL_A)      hit = HIT_CTRL;
    else if (host_addr == DATA_A) hit = HIT_DATA;
    else                          hit = HIT_NONE;
  end
endmodule

// File: rtl/idxwin_addr_latch.sv
module idxwin_addr_latch
  import idxwin_pkg::*;
#(
  parameter int IADDR_W = 28,
  parameter int MAP_W   = 2,
  parameter int BANK_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IADDR_W-1:0]             wdata,
  output logic [IADDR_W-1:0]             held,
  output logic [MAP_W-1:0]               map_sel,
  output logic [BANK_W-1:0]              bank_sel,
  output logic [IADDR_W-MAP_W-BANK_W-1:0] low_field,
  output cyc_kind_e                      cyc_kind
);
  localparam int LOW_W  = IADDR_W - MAP_W - BANK_W;
  localparam int BANK_LSB = LOW_W;
  localparam int MAP_LSB  = LOW_W + BANK_W;
  localparam logic [MAP_W-1:0] MAP_BUS = {MAP_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)        held <= '0;
    else if (wr_en) held <= wdata;
  end

  assign map_sel   = held[MAP_LSB +: MAP_W];
  assign bank_sel  = held[BANK_LSB +: BANK_W];
  assign low_field = held[LOW_W-1:0];

  always_comb begin
    cyc_kind = CYC_NONE;
    if (map_sel == MAP_BUS) begin
      if (low_field == LOW_W'(0))      cyc_kind = CYC_CMD;
      else if (low_field == LOW_W'(1)) cyc_kind = CYC_ADDR;
      else if (low_field == LOW_W'(2)) cyc_kind = CYC_DATA;
    end
  end

  // R8: the held address only moves on a control write
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(held));
endmodule

// File: rtl/idxwin_fwd.sv
module idxwin_fwd
  import idxwin_pkg::*;
#(
  parameter int IADDR_W = 28,
  parameter int DW      = 32,
  parameter int MAP_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_req,
  input  logic                  host_we,
  input  hit_e                  hit,
  input  logic [DW-1:0]         host_wdata,
  input  logic [IADDR_W-1:0]    held,
  input  logic [MAP_W-1:0]      map_sel,
  output logic                  ctrl_wr_en,
  output logic                  host_ack,
  output logic [DW-1:0]         host_rdata,
  output logic                  int_valid,
  input  logic                  int_ready,
  output logic                  int_write,
  output logic [IADDR_W-1:0]    int_addr,
  output logic [DW-1:0]         int_wdata,
  input  logic                  int_rsp_valid,
  input  logic [DW-1:0]         int_rsp_data,
  output logic [(1<<MAP_W)-1:0] map_strobe
);
  localparam int NMAP = 1 << MAP_W;
  localparam logic [NMAP-1:0] ONE = NMAP'(1);

  fwd_state_e state;
  logic       accept;

  assign accept     = host_req && (state == ST_IDLE);
  assign ctrl_wr_en = accept && (hit == HIT_CTRL) && host_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      int_valid  <= 1'b0;
      int_write  <= 1'b0;
      int_addr   <= '0;
      int_wdata  <= '0;
      map_strobe <= '0;
    end else begin
      host_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            unique case (hit)
              HIT_CTRL: begin
                host_ack   <= 1'b1;
                host_rdata <= host_we ? '0 : {{(DW-IADDR_W){1'b0}}, held};
              end
              HIT_DATA: begin
                state      <= ST_ISSUE;
                int_valid  <= 1'b1;
                int_write  <= host_we;
                int_addr   <= held;
                int_wdata  <= host_we ? host_wdata : '0;
                map_strobe <= ONE << map_sel;
              end
              default: begin
                host_ack   <= 1'b1;
                host_rdata <= '0;
              end
            endcase
          end
        end
        ST_ISSUE: begin
          if (int_ready) begin
            int_valid  <= 1'b0;
            map_strobe <= '0;
            if (int_write) begin
              host_ack   <= 1'b1;
              host_rdata <= '0;
              state      <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (int_rsp_valid) begin
            host_rdata <= int_rsp_data;
            host_ack   <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: request fields hold while the internal side stalls
  p_req_stable_r7: assert property (@(posedge clk) disable iff (rst)
    int_valid && !int_ready |=> int_valid && $stable(int_addr)
      && $stable(int_write) && $stable(int_wdata));

  // R6: no acknowledge while a read response is outstanding
  p_rd_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) && !int_rsp_valid |=> !host_ack);

  // R11: strobe is one-hot exactly while a request is pending
  p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(map_strobe) && (int_valid == ($countones(map_strobe) == 1)));

  // R10: a request arriving while busy never yields a control write
  p_busy_no_latch_r10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(held) || $past(ctrl_wr_en));
endmodule

// File: rtl/idxwin_bridge.sv
module idxwin_bridge
  import idxwin_pkg::*;
#(
  parameter int HOST_AW  = 5,
  parameter int DW       = 32,
  parameter int IADDR_W  = 28,
  parameter int MAP_W    = 2,
  parameter int BANK_W   = 2,
  parameter int CTRL_OFF = 0,
  parameter int DATA_OFF = 16,
  localparam int LOW_W   = IADDR_W - MAP_W - BANK_W,
  localparam int NMAP    = 1 << MAP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic               host_ack,
  output logic [DW-1:0]      host_rdata,
  output logic               int_valid,
  input  logic               int_ready,
  output logic               int_write,
  output logic [IADDR_W-1:0] int_addr,
  output logic [DW-1:0]      int_wdata,
  input  logic               int_rsp_valid,
  input  logic [DW-1:0]      int_rsp_data,
  output logic [MAP_W-1:0]   map_sel,
  output logic [BANK_W-1:0]  bank_sel,
  output logic [LOW_W-1:0]   low_field,
  output logic [1:0]         cyc_kind,
  output logic [NMAP-1:0]    map_strobe
);
  hit_e                hit;
  logic                ctrl_wr_en;
  logic [IADDR_W-1:0]  held;
  cyc_kind_e           kind;

  idxwin_host_decode #(
    .HOST_AW(HOST_AW), .CTRL_OFF(CTRL_OFF), .DATA_OFF(DATA_OFF)
  ) u_dec (
    .host_addr(host_addr),
    .hit      (hit)
  );

  idxwin_addr_latch #(
    .IADDR_W(IADDR_W), .MAP_W(MAP_W), .BANK_W(BANK_W)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ctrl_wr_en),
    .wdata    (host_wdata[IADDR_W-1:0]),
    .held     (held),
    .map_sel  (map_sel),
    .bank_sel (bank_sel),
    .low_field(low_field),
    .cyc_kind (kind)
  );

  idxwin_fwd #(
    .IADDR_W(IADDR_W), .DW(DW), .MAP_W(MAP_W)
  ) u_fwd (
    .clk          (clk),
    .rst          (rst),
    .host_req     (host_req),
    .host_we      (host_we),
    .hit          (hit),
    .host_wdata   (host_wdata),
    .held         (held),
    .map_sel      (map_sel),
    .ctrl_wr_en   (ctrl_wr_en),
    .host_ack     (host_ack),
    .host_rdata   (host_rdata),
    .int_valid    (int_valid),
    .int_ready    (int_ready),
    .int_write    (int_write),
    .int_addr     (int_addr),
    .int_wdata    (int_wdata),
    .int_rsp_valid(int_rsp_valid),
    .int_rsp_data (int_rsp_data),
    .map_strobe   (map_strobe)
  );

  assign cyc_kind = kind;
endmodule

// File: tb/idxwin_bridge_tb.sv
module idxwin_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        int_valid, int_write;
  logic        int_ready = 1'b0;
  logic [27:0] int_addr;
  logic [31:0] int_wdata;
  logic        int_rsp_valid = 1'b0;
  logic [31:0] int_rsp_data = '0;
  logic [1:0]  map_sel, bank_sel, cyc_kind;
  logic [23:0] low_field;
  logic [3:0]  map_strobe;

  idxwin_bridge u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .int_valid(int_valid), .int_ready(int_ready),
    .int_write(int_write), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rsp_valid(int_rsp_valid), .int_rsp_data(int_rsp_data),
    .map_sel(map_sel), .bank_sel(bank_sel), .low_field(low_field),
    .cyc_kind(cyc_kind), .map_strobe(map_strobe)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rsp_model(input logic [27:0] a);
    return {a[3:0], a} ^ 32'hC3A5_5A3C;
  endfunction

  // internal-side responder
  int cfg_rdy = 0, cfg_rsp = 0;
  int rdy_wait = -1, rsp_wait = 0;
  bit pend_rsp = 0;
  logic [27:0] pend_addr, first_addr;
  int wr_cnt = 0, rd_cnt = 0;
  logic [27:0] last_wr_addr, last_rd_addr;
  logic [31:0] last_wr_data;
  logic [3:0]  last_strobe;

  always @(negedge clk) begin
    if (!rst) begin
      int_ready = 1'b0;
      int_rsp_valid = 1'b0;
      if (pend_rsp) begin
        if (rsp_wait == 0) begin
          int_rsp_valid = 1'b1;
          int_rsp_data = rsp_model(pend_addr);
          pend_rsp = 0;
        end else rsp_wait--;
      end
      if (int_valid) begin
        if (rdy_wait < 0) begin
          rdy_wait = cfg_rdy;
          first_addr = int_addr;
        end
        if (rdy_wait == 0) begin
          int_ready = 1'b1;
          rdy_wait = -1;
          // R7: address held across the stall
          chk(int_addr == first_addr, "R7 stall addr", {4'h0, int_addr}, {4'h0, first_addr});
          last_strobe = map_strobe;
          if (int_write) begin
            wr_cnt++;
            last_wr_addr = int_addr;
            last_wr_data = int_wdata;
          end else begin
            rd_cnt++;
            last_rd_addr = int_addr;
            pend_rsp = 1;
            pend_addr = int_addr;
            rsp_wait = cfg_rsp;
          end
        end else rdy_wait--;
      end
    end
  end

  task automatic xfer(input bit we, input logic [4:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      host_req = 1'b0;
      lat++;
    end while (!host_ack && lat < 1000);
    rd = host_rdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] rd;
    int lat, wc, rc;
    logic [27:0] a;
    logic [23:0] lows[5] = '{24'd0, 24'd1, 24'd2, 24'd3, 24'hABCDE};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(host_ack == 0, "R1 ack", {31'd0, host_ack}, 0);
    chk(int_valid == 0, "R1 valid", {31'd0, int_valid}, 0);
    chk(map_strobe == 0, "R1 strobe", {28'd0, map_strobe}, 0);
    xfer(0, 5'h00, 0, rd, lat);
    chk(rd == 0, "R1 held addr", rd, 0);

    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 4; b++) begin
        for (int li = 0; li < 5; li++) begin
          logic [1:0] exp_kind;
          a = {m[1:0], b[1:0], lows[li]};
          cfg_rdy = (m + b) % 3;
          cfg_rsp = (b + li) % 4;
          // R2: write with junk in the top nibble, read back
          xfer(1, 5'h00, {4'hF, a}, rd, lat);
          chk(lat == 1, "R2 ctrl write latency", lat, 1);
          xfer(0, 5'h00, 0, rd, lat);
          chk(rd == {4'h0, a}, "R2 ctrl read", rd, {4'h0, a});
          // R3: field decode
          chk({map_sel, bank_sel, low_field} == a, "R3 fields",
              {4'h0, map_sel, bank_sel, low_field}, {4'h0, a});
          // R4: cycle kind
          exp_kind = (m == 3 && lows[li] < 3) ? lows[li][1:0] : 2'd3;
          chk(cyc_kind == exp_kind, "R4 cyc_kind", {30'd0, cyc_kind}, {30'd0, exp_kind});
          // R5: data write
          wc = wr_cnt;
          xfer(1, 5'h10, {a, 4'h5} ^ 32'h1234_5678, rd, lat);
          chk(wr_cnt == wc + 1, "R5 write count", wr_cnt, wc + 1);
          chk(last_wr_addr == a, "R5 write addr", {4'h0, last_wr_addr}, {4'h0, a});
          chk(last_wr_data == ({a, 4'h5} ^ 32'h1234_5678), "R5 write data",
              last_wr_data, {a, 4'h5} ^ 32'h1234_5678);
          chk(lat == cfg_rdy + 2, "R5 write latency", lat, cfg_rdy + 2);
          // R11: strobe
          chk(last_strobe == (4'b1 << m), "R11 strobe", {28'd0, last_strobe}, {28'd0, 4'b1 << m});
          // R6: data read
          rc = rd_cnt;
          xfer(0, 5'h10, 0, rd, lat);
          chk(rd == rsp_model(a), "R6 read data", rd, rsp_model(a));
          chk(rd_cnt == rc + 1, "R6 read count", rd_cnt, rc + 1);
          chk(lat == cfg_rdy + cfg_rsp + 3, "R6 read latency", lat, cfg_rdy + cfg_rsp + 3);
          // R8: second read same address
          xfer(0, 5'h10, 0, rd, lat);
          chk(last_rd_addr == a, "R8 persist", {4'h0, last_rd_addr}, {4'h0, a});
        end
      end
    end

    // R9: other offsets
    a = 28'h9876543;
    xfer(1, 5'h00, {4'h0, a}, rd, lat);
    wc = wr_cnt; rc = rd_cnt;
    for (int o = 0; o < 32; o++) begin
      if (o != 0 && o != 16) begin
        xfer(1, o[4:0], 32'hFFFF_FFFF, rd, lat);
        chk(lat == 1, "R9 write ack", lat, 1);
        xfer(0, o[4:0], 0, rd, lat);
        chk(rd == 0, "R9 read zero", rd, 0);
      end
    end
    chk(wr_cnt + rd_cnt == wc + rc, "R9 no internal access", wr_cnt + rd_cnt, wc + rc);
    xfer(0, 5'h00, 0, rd, lat);
    chk(rd == {4'h0, a}, "R9 held unchanged", rd, {4'h0, a});

    // R10: request during a busy read is dropped
    cfg_rdy = 3; cfg_rsp = 3;
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = 5'h10;
    @(negedge clk);
    host_req = 0;
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 5'h00; host_wdata = 32'h0123_4567;
    @(negedge clk);
    host_req = 0;
    lat = 0;
    while (!host_ack && lat < 100) begin @(negedge clk); lat++; end
    chk(host_rdata == rsp_model(a), "R10 read data", host_rdata, rsp_model(a));
    @(negedge clk);
    chk(host_ack == 0, "R10 single ack", {31'd0, host_ack}, 0);
    xfer(0, 5'h00, 0, rd, lat);
    chk(rd == {4'h0, a}, "R10 held unchanged", rd, {4'h0, a});

    summary();
  end
endmodule